// File: doc/BRIEF.md
# Masked Cache Area Purge Engine

This block cleans a region of a data cache on command. Software first programs an address mask, then writes a command word that carries a base line address and two flags. Once a command is accepted, the engine visits every line of the cache tag array, one index at a time. A line is selected when it is valid and its line address matches the base on every bit where the mask is 1.

For each selected dirty line, the engine raises a write-back request to the backing memory. It holds that request until the memory acknowledges it, and then marks the line clean. If the command asked for invalidation, every selected line also loses its valid bit: a dirty line after its write-back, a clean line straight away. A mask of all zeros selects every valid line, so one command cleans the whole cache. A mask with ones in its upper bits selects one aligned power-of-two region.

The tag array is a behavioural model. It has a load port that stands in for the fill path and a probe port for observing each line. The lookup path is not part of this block. A busy output stays high for the whole walk. Software polls it before it issues a new command.

Top module: `cache_area_purge`

## Requirements
- R1: A write with `cfg_sel`=1 is a command. `cfg_wdata` bits [31:5] hold the base line address, bit 0 is the purge flag and bit 1 is the invalidate flag. A command with the purge flag set, written while idle with `dc_en`=1, is accepted and `busy` reads 1 from the next cycle.
- R2: A write with `cfg_sel`=0 loads the mask from `cfg_wdata` bits [31:5]. A line is selected when it is valid and (line address XOR base) AND mask is zero.
- R3: An all-zero mask selects every valid line.
- R4: Each selected dirty line produces exactly one `wb_req`, with `wb_addr` equal to the line address shifted left by 5 (low 5 bits zero). The request and address are held until `wb_ack`, and the line is clean afterwards.
- R5: With the invalidate flag set, every selected line is invalid when the walk ends. Without it, selected lines stay valid.
- R6: Lines that are not selected keep their valid bit, dirty bit and tag, and produce no write-back.
- R7: Lines are visited in ascending index order, so write-backs appear in index order.
- R8: `busy` stays 1 until the last line has been processed. With no write-back needed it is high for exactly NUM_LINES cycles. `wb_req` is never high while `busy` is 0.
- R9: Mask and command writes made while `busy` is 1 are ignored, and `busy` stays set.
- R10: A command written with `dc_en`=0, or with the purge flag clear, is ignored and `busy` stays 0.
- R11: After reset, `busy` and `wb_req` are 0, every line is invalid and clean, and the mask is zero.
- R12: Line loads made while `busy` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dc_en | input | 1 | Data cache enabled; commands are only accepted when it is 1 |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the mask register, 1 selects the command register |
| cfg_wdata | input | ADDR_W | Register write data |
| busy | output | 1 | Walk in progress |
| ld_en | input | 1 | Line load strobe (stands in for the fill path) |
| ld_idx | input | log2(NUM_LINES) | Line index to load |
| ld_tag | input | ADDR_W-5 | Line address to store |
| ld_valid | input | 1 | Valid bit to store |
| ld_dirty | input | 1 | Dirty bit to store |
| pr_idx | input | log2(NUM_LINES) | Line index to observe |
| pr_valid | output | 1 | Valid bit of the observed line |
| pr_dirty | output | 1 | Dirty bit of the observed line |
| pr_tag | output | ADDR_W-5 | Line address of the observed line |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | ADDR_W | Byte address of the line being written back |
| wb_ack | input | 1 | Write-back accepted by memory |

## Verification
A wrong scan index or a wrong match decision shows up on the write-back port within the same walk. The symptom is a missing request, an extra request or one out of index order, and the sequence of `wb_addr` values compared against a model exposes it before `busy` falls. A wrong update of the valid or dirty bits is invisible at the write-back port. It can only be seen by probing each line once the walk is over. A stuck state register shows as `busy` running past NUM_LINES plus the write-back wait cycles, or as a command that starts nothing.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WB   = 2'd2
  } cap_state_e;

  localparam int CMD_PURGE_BIT = 0;
  localparam int CMD_INV_BIT   = 1;
endpackage

// File: rtl/cap_tag_array.sv
module cap_tag_array #(
  parameter int NUM_LINES = 64,
  parameter int LA_W      = 27,
  parameter int IDX_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [LA_W-1:0]  ld_tag,
  input  logic             ld_valid,
  input  logic             ld_dirty,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_clr_valid,
  input  logic             upd_clr_dirty,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [LA_W-1:0]  rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  input  logic [IDX_W-1:0] pr_idx,
  output logic [LA_W-1:0]  pr_tag,
  output logic             pr_valid,
  output logic             pr_dirty
);
  logic [NUM_LINES-1:0] valid_w;
  logic [NUM_LINES-1:0] dirty_w;
  logic [LA_W-1:0]      tag_w [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic            ld_hit, up_hit, line_en;
    logic            v_q, v_d, d_q, d_d;
    logic [LA_W-1:0] t_q;

    assign ld_hit  = ld_en  && (ld_idx  == IDX_W'(g));
    assign up_hit  = upd_en && (upd_idx == IDX_W'(g));
    assign line_en = ld_hit || up_hit;

    always_comb begin
      v_d = v_q;
      d_d = d_q;
      if (up_hit) begin
        if (upd_clr_valid) v_d = 1'b0;
        if (upd_clr_dirty) d_d = 1'b0;
      end else if (ld_hit) begin
        v_d = ld_valid;
        d_d = ld_dirty;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (line_en) begin
        v_q <= v_d;
        d_q <= d_d;
      end
    end

    always_ff @(posedge clk) begin
      if (ld_hit && !up_hit) t_q <= ld_tag;
    end

    assign valid_w[g] = v_q;
    assign dirty_w[g] = d_q;
    assign tag_w[g]   = t_q;
  end

  assign rd_tag   = tag_w[rd_idx];
  assign rd_valid = valid_w[rd_idx];
  assign rd_dirty = dirty_w[rd_idx];
  assign pr_tag   = tag_w[pr_idx];
  assign pr_valid = valid_w[pr_idx];
  assign pr_dirty = dirty_w[pr_idx];
endmodule

// File: rtl/cap_match.sv
module cap_match #(
  parameter int LA_W = 27
) (
  input  logic            line_valid,
  input  logic [LA_W-1:0] line_tag,
  input  logic [LA_W-1:0] base,
  input  logic [LA_W-1:0] mask,
  output logic            hit
);
  logic [LA_W-1:0] diff;

  assign diff = (line_tag ^ base) & mask;
  assign hit  = line_valid && (diff == '0);
endmodule

// File: rtl/cap_scan_fsm.sv
module cap_scan_fsm
  import cap_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFS_W     = 5,
  parameter int LA_W      = 27,
  parameter int IDX_W     = 6,
  parameter int NUM_LINES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [LA_W-1:0]   cmd_base,
  input  logic              cmd_purge,
  input  logic              cmd_inv,
  input  logic              dc_en,
  input  logic              line_hit,
  input  logic              line_dirty,
  input  logic [LA_W-1:0]   line_tag,
  input  logic              wb_ack,
  output logic [IDX_W-1:0]  scan_idx,
  output logic              upd_en,
  output logic              upd_clr_valid,
  output logic              upd_clr_dirty,
  output logic              busy,
  output logic [LA_W-1:0]   base,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  cap_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LA_W-1:0]  base_q, wbl_q, wbl_d;
  logic             inv_q;
  logic             cmd_go, step, last, wb_take;

  assign last    = (idx_q == LAST_IDX);
  assign cmd_go  = (state_q == ST_IDLE) && cmd_wr && dc_en && cmd_purge;
  assign wb_take = (state_q == ST_SCAN) && line_hit && line_dirty;

  always_comb begin
    state_d       = state_q;
    idx_d         = idx_q;
    wbl_d         = wbl_q;
    upd_en        = 1'b0;
    upd_clr_valid = 1'b0;
    upd_clr_dirty = 1'b0;
    step          = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_go) begin
          state_d = ST_SCAN;
          idx_d   = '0;
        end
      end
      ST_SCAN: begin
        if (wb_take) begin
          state_d = ST_WB;
          wbl_d   = line_tag;
        end else begin
          step = 1'b1;
          if (line_hit && inv_q) begin
            upd_en        = 1'b1;
            upd_clr_valid = 1'b1;
          end
        end
      end
      ST_WB: begin
        if (wb_ack) begin
          step          = 1'b1;
          upd_en        = 1'b1;
          upd_clr_dirty = 1'b1;
          upd_clr_valid = inv_q;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (step) begin
      if (last) begin
        state_d = ST_IDLE;
      end else begin
        state_d = ST_SCAN;
        idx_d   = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      inv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cmd_go || step) idx_q <= idx_d;
      if (cmd_go)         inv_q <= cmd_inv;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd_go)  base_q <= cmd_base;
    if (wb_take) wbl_q  <= wbl_d;
  end

  assign scan_idx = idx_q;
  assign busy     = (state_q != ST_IDLE);
  assign base     = base_q;
  assign wb_req   = (state_q == ST_WB);
  assign wb_addr  = {wbl_q, {OFS_W{1'b0}}};

  AST_CMD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_wr && dc_en && cmd_purge) |=> busy); // R1
  AST_CMD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_wr && !(dc_en && cmd_purge)) |=> !busy); // R10
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> ($stable(base_q) && $stable(inv_q))); // R9
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr))); // R4
  AST_SCAN_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || (scan_idx >= $past(scan_idx)))); // R7
endmodule

// File: rtl/cache_area_purge.sv
module cache_area_purge #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int NUM_LINES  = 64
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  dc_en,
  input  logic                                  cfg_wr_en,
  input  logic                                  cfg_sel,
  input  logic [ADDR_W-1:0]                     cfg_wdata,
  output logic                                  busy,
  input  logic                                  ld_en,
  input  logic [$clog2(NUM_LINES)-1:0]          ld_idx,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  ld_tag,
  input  logic                                  ld_valid,
  input  logic                                  ld_dirty,
  input  logic [$clog2(NUM_LINES)-1:0]          pr_idx,
  output logic                                  pr_valid,
  output logic                                  pr_dirty,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  pr_tag,
  output logic                                  wb_req,
  output logic [ADDR_W-1:0]                     wb_addr,
  input  logic                                  wb_ack
);
  import cap_pkg::*;

  localparam int OFS_W = $clog2(LINE_BYTES);
  localparam int LA_W  = ADDR_W - OFS_W;
  localparam int IDX_W = $clog2(NUM_LINES);

  logic [LA_W-1:0]  mask_q, mask_d, base, line_tag, cmd_base;
  logic             mask_en, cmd_wr, cmd_purge, cmd_inv;
  logic             line_valid, line_dirty, line_hit, ld_ok;
  logic             upd_en, upd_clr_valid, upd_clr_dirty;
  logic [IDX_W-1:0] scan_idx;
  logic             unused_cfg_bits;

  assign cmd_base        = cfg_wdata[ADDR_W-1:OFS_W];
  assign cmd_purge       = cfg_wdata[CMD_PURGE_BIT];
  assign cmd_inv         = cfg_wdata[CMD_INV_BIT];
  assign cmd_wr          = cfg_wr_en && cfg_sel;
  assign unused_cfg_bits = ^cfg_wdata[OFS_W-1:CMD_INV_BIT+1];

  assign mask_en = cfg_wr_en && !cfg_sel && !busy;
  assign mask_d  = cfg_wdata[ADDR_W-1:OFS_W];
  assign ld_ok   = ld_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  cap_tag_array #(
    .NUM_LINES (NUM_LINES),
    .LA_W      (LA_W),
    .IDX_W     (IDX_W)
  ) u_tags (
    .clk           (clk),
    .rst_n         (rst_n),
    .ld_en         (ld_ok),
    .ld_idx        (ld_idx),
    .ld_tag        (ld_tag),
    .ld_valid      (ld_valid),
    .ld_dirty      (ld_dirty),
    .upd_en        (upd_en),
    .upd_idx       (scan_idx),
    .upd_clr_valid (upd_clr_valid),
    .upd_clr_dirty (upd_clr_dirty),
    .rd_idx        (scan_idx),
    .rd_tag        (line_tag),
    .rd_valid      (line_valid),
    .rd_dirty      (line_dirty),
    .pr_idx        (pr_idx),
    .pr_tag        (pr_tag),
    .pr_valid      (pr_valid),
    .pr_dirty      (pr_dirty)
  );

  cap_match #(.LA_W(LA_W)) u_match (
    .line_valid (line_valid),
    .line_tag   (line_tag),
    .base       (base),
    .mask       (mask_q),
    .hit        (line_hit)
  );

  cap_scan_fsm #(
    .ADDR_W    (ADDR_W),
    .OFS_W     (OFS_W),
    .LA_W      (LA_W),
    .IDX_W     (IDX_W),
    .NUM_LINES (NUM_LINES)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_wr        (cmd_wr),
    .cmd_base      (cmd_base),
    .cmd_purge     (cmd_purge),
    .cmd_inv       (cmd_inv),
    .dc_en         (dc_en),
    .line_hit      (line_hit),
    .line_dirty    (line_dirty),
    .line_tag      (line_tag),
    .wb_ack        (wb_ack),
    .scan_idx      (scan_idx),
    .upd_en        (upd_en),
    .upd_clr_valid (upd_clr_valid),
    .upd_clr_dirty (upd_clr_dirty),
    .busy          (busy),
    .base          (base),
    .wb_req        (wb_req),
    .wb_addr       (wb_addr)
  );

  AST_WB_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (((wb_addr[ADDR_W-1:OFS_W] ^ base) & mask_q) == '0)); // R2
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wb_req); // R8
  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_wr_en && !cfg_sel) |=> $stable(mask_q)); // R9
endmodule

// File: tb/cache_area_purge_bench.sv
module cache_area_purge_bench;
  localparam int N    = 64;
  localparam int LA_W = 27;

  logic            clk = 1'b0;
  logic            rst_n, dc_en, cfg_wr_en, cfg_sel, ld_en, ld_valid, ld_dirty, wb_ack;
  logic [31:0]     cfg_wdata, wb_addr;
  logic [5:0]      ld_idx, pr_idx;
  logic [LA_W-1:0] ld_tag, pr_tag;
  logic            busy, pr_valid, pr_dirty, wb_req;

  cache_area_purge u_cache_area_purge (
    .clk(clk), .rst_n(rst_n), .dc_en(dc_en), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .ld_en(ld_en), .ld_idx(ld_idx), .ld_tag(ld_tag),
    .ld_valid(ld_valid), .ld_dirty(ld_dirty), .pr_idx(pr_idx), .pr_valid(pr_valid),
    .pr_dirty(pr_dirty), .pr_tag(pr_tag), .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic [LA_W-1:0] m_tag [N];
  bit              m_valid [N];
  bit              m_dirty [N];
  logic [31:0]     exp_wb [N];
  int              exp_n;
  logic [31:0]     rec_wb [N];
  int              rec_n = 0;
  int              ack_wait = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic bit sel(input int i, input logic [LA_W-1:0] b, input logic [LA_W-1:0] m);
    return m_valid[i] && (((m_tag[i] ^ b) & m) == '0);
  endfunction

  // memory side: acknowledge after a short random wait, record addresses
  initial begin
    wb_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (wb_ack) wb_ack = 1'b0;
      else if (wb_req) begin
        if (ack_wait == 0) begin
          wb_ack = 1'b1;
          if (rec_n < N) rec_wb[rec_n] = wb_addr;
          rec_n++;
          ack_wait = int'($urandom % 4);
        end else ack_wait--;
      end
    end
  end

  task automatic write_reg(input bit s, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic load_line(input int i, input logic [LA_W-1:0] t, input bit v, input bit d, input bit upd_model);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 6'(i); ld_tag = t; ld_valid = v; ld_dirty = d;
    @(negedge clk);
    ld_en = 1'b0;
    if (upd_model) begin m_tag[i] = t; m_valid[i] = v; m_dirty[i] = d; end
  endtask

  task automatic start_cmd(input logic [LA_W-1:0] b, input logic [LA_W-1:0] m, input bit inv);
    exp_n = 0;
    for (int i = 0; i < N; i++) begin
      if (sel(i, b, m)) begin
        if (m_dirty[i]) begin exp_wb[exp_n] = {m_tag[i], 5'b0}; exp_n++; end
        m_dirty[i] = 1'b0;
        if (inv) m_valid[i] = 1'b0;
      end
    end
    rec_n = 0;
    write_reg(1'b0, {m, 5'b0});
    write_reg(1'b1, {b, 3'b0, inv, 1'b1});
  endtask

  task automatic finish_cmd(input string req, output int cyc);
    cyc = 0;
    while (busy && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(!busy, "R8 walk ends", 64'(busy), 64'd0);
    @(negedge clk);
    chk(rec_n == exp_n, {req, " R4 write-back count"}, 64'(rec_n), 64'(exp_n));
    for (int k = 0; k < exp_n && k < rec_n; k++)
      chk(rec_wb[k] == exp_wb[k], {req, " R7 write-back order/address"}, 64'(rec_wb[k]), 64'(exp_wb[k]));
  endtask

  task automatic compare_lines(input string req);
    int bad = 0;
    for (int i = 0; i < N; i++) begin
      pr_idx = 6'(i);
      #1;
      if (pr_valid !== m_valid[i] || pr_dirty !== m_dirty[i] || (m_valid[i] && pr_tag !== m_tag[i])) begin
        if (bad == 0)
          $display("FAIL %s line %0d actual v=%0b d=%0b t=%0h expected v=%0b d=%0b t=%0h",
                   req, i, pr_valid, pr_dirty, pr_tag, m_valid[i], m_dirty[i], m_tag[i]);
        bad++;
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc;
    logic [LA_W-1:0] b, m;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; dc_en = 1'b1; cfg_wr_en = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    ld_en = 1'b0; ld_idx = '0; ld_tag = '0; ld_valid = 1'b0; ld_dirty = 1'b0; pr_idx = '0;
    for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_valid[i] = 1'b0; m_dirty[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk(busy == 1'b0, "R11 busy after reset", 64'(busy), 64'd0);
    chk(wb_req == 1'b0, "R11 wb_req after reset", 64'(wb_req), 64'd0);
    compare_lines("R11 lines after reset");

    // R3: all-zero mask, purge only, selects every valid line
    for (int i = 0; i < N; i++)
      load_line(i, LA_W'($urandom), ($urandom % 4) != 0, ($urandom % 2) == 1, 1'b1);
    start_cmd(LA_W'($urandom), '0, 1'b0);
    chk(busy == 1'b1, "R1 busy after command", 64'(busy), 64'd1);
    finish_cmd("R3 full purge", cyc);
    compare_lines("R3 R5 lines after full purge");

    // R8: every line clean, so walk is exactly N cycles; R5 invalidate clean lines
    b = m_tag[5];
    m = ~LA_W'(0);
    start_cmd(b, m, 1'b1);
    finish_cmd("R8 clean walk", cyc);
    chk(cyc == N, "R8 busy length", 64'(cyc), 64'(N));
    compare_lines("R5 clean invalidate");

    // R10: dc_en low, and purge flag clear, both ignored
    for (int i = 0; i < N; i++)
      load_line(i, 27'h40 | LA_W'($urandom % 8), 1'b1, 1'b1, 1'b1);
    dc_en = 1'b0;
    write_reg(1'b1, {27'h40, 3'b0, 1'b1, 1'b1});
    chk(busy == 1'b0, "R10 ignored when cache disabled", 64'(busy), 64'd0);
    dc_en = 1'b1;
    write_reg(1'b1, {27'h40, 3'b0, 1'b1, 1'b0});
    chk(busy == 1'b0, "R10 ignored without purge flag", 64'(busy), 64'd0);
    repeat (3) @(negedge clk);
    chk(rec_n == 0 && !wb_req, "R10 no write-back", 64'(rec_n), 64'd0);
    compare_lines("R10 lines untouched");

    // R9, R12: writes and loads during a walk are ignored
    load_line(63, 27'h7, 1'b0, 1'b0, 1'b1);
    start_cmd(27'h40, 27'h7FFFFF8, 1'b0);
    write_reg(1'b1, {27'h0, 3'b0, 1'b1, 1'b1});
    chk(busy == 1'b1, "R9 busy stays set", 64'(busy), 64'd1);
    write_reg(1'b0, 32'hFFFF_FFE0);
    load_line(63, 27'h41, 1'b1, 1'b1, 1'b0);
    finish_cmd("R9 first command only", cyc);
    compare_lines("R9 R12 lines after walk with ignored writes");

    // R2 R4 R5 R6 R7: random aligned regions
    for (int it = 0; it < 12; it++) begin
      for (int i = 0; i < N; i++)
        load_line(i, 27'h100 | LA_W'($urandom % 64), ($urandom % 5) != 0, ($urandom % 2) == 1, 1'b1);
      m = ~((LA_W'(1) << ($urandom % 6)) - 1'b1);
      b = (27'h100 | LA_W'($urandom % 64)) & m;
      start_cmd(b, m, ($urandom % 2) == 1);
      finish_cmd("R2 R6 random region", cyc);
      compare_lines("R5 R6 random region lines");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule